// File: doc/BRIEF.md
# Lockable SDRAM Configuration Register

This block is the configuration register of a single-data-rate SDRAM controller. It stores the data-bus width, the CAS latency, the internal bank count, the chip-select mode and the page size. It also holds a master enable and two unlock bits. It takes writes from a simple bus port with byte-lane strobes. The full register is always visible on a read-data output.

The two unlock bits guard individual fields. The boot-unlock bit guards the master enable. The timing-unlock bit guards the CAS-latency field and is also exported as the write enable of the external timing registers. In both cases, the unlock bit that counts is the one already stored when the write arrives.

Any write that a geometry or latency field accepts raises a one-cycle request to restart SDRAM initialization. A field write that carries a reserved code is dropped for that field alone and recorded in a sticky error flag. The block also refuses to clear the master enable while the controller reports self-refresh. Decoded values (column-address width, bank count, latency, width mode) are driven straight to the controller core.

Top module: `sdram_cfg_reg`

## Requirements
- R1: After reset, rd_data reads 0x00010621: enabled, 32-bit bus, CAS latency 3, bank code 2, page code 1, both unlock bits clear. init_start and both error flags are 0.
- R2: Bits 31:24, 22:17, 13:12, 8:7 and the chip-select bit 3 always read 0. A write with bit 3 set is rejected for that field and sets err_rsvd.
- R3: Byte lane 0 carries bits 7:0, lane 1 carries bits 15:8 and lane 2 carries bits 23:16. A field changes only if its lane strobe is set, and a write with no strobes changes nothing.
- R4: The enable bit 16 takes the written value only when the stored boot-unlock bit 23 is 1 before the write. Bit 23 itself is written whenever lane 2 is strobed.
- R5: The CAS-latency field 11:9 takes the written value only when the stored timing-unlock bit 15 is 1 before the write. tim_wr_en equals the stored bit 15.
- R6: The legal codes are CAS latency 2 or 3, bank code 0 to 2 and page code 0 to 3. A write that reaches a field with another code leaves that field unchanged and sets err_rsvd. Other fields in the same write still apply.
- R7: init_start is 1 in exactly the cycle after a write that accepts at least one of these fields: width bit 14 (accepted whenever lane 1 is strobed), CAS latency, bank, chip-select (value 0) or page. At all other times init_start is 0.
- R8: A write that would clear an enable of 1 while self_refresh is 1 leaves the enable at 1 and sets err_sr.
- R9: init_en and refresh_en both follow the enable bit. Read and write transactions are never gated by this block.
- R10: col_bits = 8 + page code, bank_cnt = 1 << bank code, cas_lat = stored latency, bus16 = bit 14 (1 means a 16-bit bus).
- R11: err_rsvd and err_sr stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte-lane strobes |
| self_refresh | input | 1 | Controller is in self-refresh |
| rd_data | output | 32 | Register contents |
| init_start | output | 1 | One-cycle initialization request |
| tim_wr_en | output | 1 | Write enable for the timing registers |
| init_en | output | 1 | Initialization allowed |
| refresh_en | output | 1 | Refresh allowed |
| bus16 | output | 1 | 16-bit data bus selected |
| cas_lat | output | 3 | CAS latency in cycles |
| bank_cnt | output | 3 | Internal bank count |
| col_bits | output | 4 | Column address bits |
| err_rsvd | output | 1 | Sticky reserved-code error |
| err_sr | output | 1 | Sticky blocked-clear error |

## Verification
A single lane-0 write can reject a reserved bank or page code and still accept the other fields. In that write, the error flag and the initialization request rise together. The bench sweeps all 256 values of lane 0, and lane 1 both locked and unlocked. For each value it predicts, field by field, whether each part is accepted or rejected, then compares init_start, err_rsvd and the readback in the cycle after the write. Lane 2 is swept with self-refresh low and high, which exercises a blocked enable clear together with an unlock change in the same write.

// File: rtl/sdram_cfg_pkg.sv
package sdram_cfg_pkg;
  localparam int CFG_W   = 32;
  localparam int BE_W    = CFG_W / 8;
  localparam int COL_MIN = 8;

  localparam int B_BOOT  = 23;
  localparam int B_EN    = 16;
  localparam int B_TIM   = 15;
  localparam int B_W16   = 14;
  localparam int B_CL    = 9;
  localparam int B_BANK  = 4;
  localparam int B_CS    = 3;
  localparam int B_PAGE  = 0;

  typedef struct packed {
    logic       boot_unlk;
    logic       en;
    logic       tim_unlk;
    logic       w16;
    logic [2:0] cl;
    logic [2:0] bank;
    logic [2:0] page;
  } cfg_t;

  localparam cfg_t CFG_RST = '{boot_unlk: 1'b0, en: 1'b1, tim_unlk: 1'b0,
                               w16: 1'b0, cl: 3'd3, bank: 3'd2, page: 3'd1};

  function automatic logic cl_ok(input logic [2:0] c);
    return (c == 3'd2) || (c == 3'd3);
  endfunction

  function automatic logic bank_ok(input logic [2:0] c);
    return c < 3'd3;
  endfunction

  function automatic logic page_ok(input logic [2:0] c);
    return c < 3'd4;
  endfunction

  function automatic logic [CFG_W-1:0] pack(input cfg_t c);
    logic [CFG_W-1:0] v;
    v = '0;
    v[B_BOOT]        = c.boot_unlk;
    v[B_EN]          = c.en;
    v[B_TIM]         = c.tim_unlk;
    v[B_W16]         = c.w16;
    v[B_CL+:3]       = c.cl;
    v[B_BANK+:3]     = c.bank;
    v[B_PAGE+:3]     = c.page;
    return v;
  endfunction
endpackage

// File: rtl/sdram_cfg_rst_sync.sv
module sdram_cfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/sdram_cfg_wr_ctl.sv
module sdram_cfg_wr_ctl
  import sdram_cfg_pkg::*;
(
  input  cfg_t             cur,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic [BE_W-1:0]  wr_be,
  input  logic             self_refresh,
  output cfg_t             nxt,
  output logic             init_req,
  output logic             rsvd_hit,
  output logic             sr_block
);
  always_comb begin
    nxt      = cur;
    init_req = 1'b0;
    rsvd_hit = 1'b0;
    sr_block = 1'b0;
    if (wr_en) begin
      if (wr_be[0]) begin
        if (page_ok(wr_data[B_PAGE+:3])) begin
          nxt.page = wr_data[B_PAGE+:3];
          init_req = 1'b1;
        end else begin
          rsvd_hit = 1'b1;
        end
        if (bank_ok(wr_data[B_BANK+:3])) begin
          nxt.bank = wr_data[B_BANK+:3];
          init_req = 1'b1;
        end else begin
          rsvd_hit = 1'b1;
        end
        if (!wr_data[B_CS]) init_req = 1'b1;
        else                rsvd_hit = 1'b1;
      end
      if (wr_be[1]) begin
        nxt.w16      = wr_data[B_W16];
        nxt.tim_unlk = wr_data[B_TIM];
        init_req     = 1'b1;
        if (cur.tim_unlk) begin
          if (cl_ok(wr_data[B_CL+:3])) nxt.cl = wr_data[B_CL+:3];
          else                         rsvd_hit = 1'b1;
        end
      end
      if (wr_be[2]) begin
        nxt.boot_unlk = wr_data[B_BOOT];
        if (cur.boot_unlk) begin
          if (!wr_data[B_EN] && cur.en && self_refresh) sr_block = 1'b1;
          else                                          nxt.en = wr_data[B_EN];
        end
      end
    end
  end
endmodule

// File: rtl/sdram_cfg_decode.sv
module sdram_cfg_decode
  import sdram_cfg_pkg::*;
(
  input  cfg_t       cfg,
  output logic       bus16,
  output logic [2:0] cas_lat,
  output logic [2:0] bank_cnt,
  output logic [3:0] col_bits
);
  assign bus16    = cfg.w16;
  assign cas_lat  = cfg.cl;
  assign bank_cnt = 3'(3'd1 << cfg.bank[1:0]);
  assign col_bits = 4'(COL_MIN) + {1'b0, cfg.page};
endmodule

// File: rtl/sdram_cfg_reg.sv
module sdram_cfg_reg
  import sdram_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic [BE_W-1:0]  wr_be,
  input  logic             self_refresh,
  output logic [CFG_W-1:0] rd_data,
  output logic             init_start,
  output logic             tim_wr_en,
  output logic             init_en,
  output logic             refresh_en,
  output logic             bus16,
  output logic [2:0]       cas_lat,
  output logic [2:0]       bank_cnt,
  output logic [3:0]       col_bits,
  output logic             err_rsvd,
  output logic             err_sr
);
  logic rst_sync_n;
  cfg_t cfg_q, cfg_d;
  logic init_req, rsvd_hit, sr_block;

  sdram_cfg_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  sdram_cfg_wr_ctl u_wr (
    .cur(cfg_q), .wr_en(wr_en), .wr_data(wr_data), .wr_be(wr_be),
    .self_refresh(self_refresh), .nxt(cfg_d), .init_req(init_req),
    .rsvd_hit(rsvd_hit), .sr_block(sr_block)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cfg_q      <= CFG_RST;
      init_start <= 1'b0;
      err_rsvd   <= 1'b0;
      err_sr     <= 1'b0;
    end else begin
      if (wr_en) cfg_q <= cfg_d;
      init_start <= init_req;
      if (rsvd_hit) err_rsvd <= 1'b1;
      if (sr_block) err_sr   <= 1'b1;
    end
  end

  sdram_cfg_decode u_dec (
    .cfg(cfg_q), .bus16(bus16), .cas_lat(cas_lat),
    .bank_cnt(bank_cnt), .col_bits(col_bits)
  );

  assign rd_data    = pack(cfg_q);
  assign tim_wr_en  = cfg_q.tim_unlk;
  assign init_en    = cfg_q.en;
  assign refresh_en = cfg_q.en;
endmodule

// File: rtl/sdram_cfg_chk.sv
module sdram_cfg_chk (
  input logic        clk,
  input logic        rst_sync_n,
  input logic        wr_en,
  input logic        self_refresh,
  input logic [31:0] rd_data,
  input logic        init_start,
  input logic        tim_wr_en,
  input logic [2:0]  cas_lat,
  input logic        err_rsvd,
  input logic        err_sr
);
  p_cs_zero_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_data[3] == 1'b0);
  p_en_locked_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rd_data[23] |=> $stable(rd_data[16]));
  p_cl_locked_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !tim_wr_en |=> $stable(rd_data[11:9]));
  p_cl_legal_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cas_lat == 3'd2) || (cas_lat == 3'd3));
  p_init_cause_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !wr_en |=> !init_start);
  p_sr_keep_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (self_refresh && rd_data[16]) |=> rd_data[16]);
  p_rsvd_sticky_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    err_rsvd |=> err_rsvd);
  p_sr_sticky_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    err_sr |=> err_sr);
endmodule

bind sdram_cfg_reg sdram_cfg_chk u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .wr_en(wr_en),
  .self_refresh(self_refresh), .rd_data(rd_data), .init_start(init_start),
  .tim_wr_en(tim_wr_en), .cas_lat(cas_lat), .err_rsvd(err_rsvd),
  .err_sr(err_sr)
);

// File: tb/sdram_cfg_reg_tb.sv
module sdram_cfg_reg_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [3:0]  wr_be;
  logic        self_refresh;
  logic [31:0] rd_data;
  logic        init_start, tim_wr_en, init_en, refresh_en, bus16;
  logic [2:0]  cas_lat, bank_cnt;
  logic [3:0]  col_bits;
  logic        err_rsvd, err_sr;

  int n_chk = 0;
  int n_bad = 0;

  // expected model
  logic       e_boot, e_en, e_tim, e_w16, e_init, e_ea, e_es;
  logic [2:0] e_cl, e_bank, e_page;

  always #4 clk = ~clk;

  sdram_cfg_reg u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_be(wr_be),
    .self_refresh(self_refresh), .rd_data(rd_data), .init_start(init_start),
    .tim_wr_en(tim_wr_en), .init_en(init_en), .refresh_en(refresh_en),
    .bus16(bus16), .cas_lat(cas_lat), .bank_cnt(bank_cnt), .col_bits(col_bits),
    .err_rsvd(err_rsvd), .err_sr(err_sr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] e_word();
    logic [31:0] v;
    v = '0;
    v[23] = e_boot; v[16] = e_en; v[15] = e_tim; v[14] = e_w16;
    v[11:9] = e_cl; v[6:4] = e_bank; v[2:0] = e_page;
    return v;
  endfunction

  task automatic check_all(input string ctx);
    chk({ctx, " R1 R2 R3 R4 R5 R6 readback"}, rd_data, e_word());
    chk({ctx, " R7 init_start"}, 32'(init_start), 32'(e_init));
    chk({ctx, " R6 R11 err_rsvd"}, 32'(err_rsvd), 32'(e_ea));
    chk({ctx, " R8 R11 err_sr"}, 32'(err_sr), 32'(e_es));
    chk({ctx, " R5 tim_wr_en"}, 32'(tim_wr_en), 32'(e_tim));
    chk({ctx, " R9 enables"}, {30'd0, init_en, refresh_en}, {30'd0, e_en, e_en});
    chk({ctx, " R10 decode"}, {18'd0, bus16, cas_lat, bank_cnt, col_bits, 3'd0},
        {18'd0, e_w16, e_cl, 3'(3'd1 << e_bank[1:0]), 4'(8 + e_page), 3'd0});
  endtask

  task automatic model_reset();
    e_boot = 0; e_en = 1; e_tim = 0; e_w16 = 0; e_cl = 3; e_bank = 2;
    e_page = 1; e_init = 0; e_ea = 0; e_es = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 0; wr_be = 0; wr_data = 0; self_refresh = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    model_reset();
  endtask

  task automatic wr(input logic [31:0] d, input logic [3:0] be, input logic sr,
                    input string ctx);
    logic ob, ot;
    ob = e_boot; ot = e_tim; e_init = 0;
    if (be[0]) begin
      if (d[2:0] < 4) begin e_page = d[2:0]; e_init = 1; end else e_ea = 1;
      if (d[6:4] < 3) begin e_bank = d[6:4]; e_init = 1; end else e_ea = 1;
      if (!d[3]) e_init = 1; else e_ea = 1;
    end
    if (be[1]) begin
      e_w16 = d[14]; e_tim = d[15]; e_init = 1;
      if (ot) begin
        if (d[11:9] == 2 || d[11:9] == 3) e_cl = d[11:9]; else e_ea = 1;
      end
    end
    if (be[2]) begin
      e_boot = d[23];
      if (ob) begin
        if (!d[16] && e_en && sr) e_es = 1; else e_en = d[16];
      end
    end
    wr_en = 1; wr_data = d; wr_be = be; self_refresh = sr;
    @(negedge clk);
    wr_en = 0; wr_be = 0;
    check_all(ctx);
    e_init = 0;
  endtask

  initial begin
    int wd;
    for (wd = 0; wd < 150000; wd++) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    check_all("reset R1");
    @(negedge clk);
    check_all("idle after reset R1 R7");

    // no strobes: nothing changes (R3)
    wr(32'hFFFF_FFFF, 4'b0000, 1'b0, "no strobe R3");
    wr(32'h0000_0000, 4'b1000, 1'b0, "lane3 only R3");

    // lane 0 exhaustive (R2 R6 R7 R10)
    for (int v = 0; v < 256; v++) wr(32'(v), 4'b0001, 1'b0, "lane0 sweep R6");

    // lane 1 locked then unlocked (R5 R6 R7)
    for (int v = 0; v < 256; v++) wr(32'(v) << 8, 4'b0010, 1'b0, "lane1 sweep R5");
    for (int v = 0; v < 256; v++) wr((32'(v) << 8) | 32'h8000, 4'b0010, 1'b0, "lane1 unlocked R5");

    // lane 2 with self-refresh low then high (R4 R8)
    for (int v = 0; v < 256; v++) wr(32'(v) << 16, 4'b0100, 1'b0, "lane2 sweep R4");
    wr(32'h0081_0000, 4'b0100, 1'b0, "enable on R4");
    for (int v = 0; v < 256; v++) wr(32'(v) << 16, 4'b0100, 1'b1, "lane2 selfref R8");

    // full-word writes with both unlocks (R3 R7)
    wr(32'h0081_8000, 4'b1111, 1'b0, "unlock all R4 R5");
    wr(32'h0080_C413, 4'b1111, 1'b0, "full word R3");
    wr(32'h0081_8620, 4'b0111, 1'b0, "full word2 R3");

    // second reset clears sticky errors (R11)
    do_reset();
    check_all("re-reset R11 R1");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule